// File: doc/BRIEF.md
# Isolated I/O Port Unit

This block is a small I/O subsystem hanging off a processor-style bus. The bus carries an address, a 16-bit write data path, a read data path, separate read and write strobes, and one line that tells memory cycles from I/O cycles. The block decodes only I/O cycles. It holds two ports in a 64K I/O space that is separate from memory: an input port that presents switch levels, and an output port that drives LEDs.

The input port acts like a tri-state buffer. It places the switch levels on the read data path, with a drive-enable, only while its own address is being read in an I/O cycle. At every other time it presents all zeros with the enable low. The output port acts like a latch built from 8-bit byte lanes. It captures the write data on an I/O write to its own address and holds the value on its pins until the next such write. A parameter chooses 8-bit decoding, which compares address bits 7:0, or 16-bit decoding, which compares bits 15:0. Both port addresses are parameters.

Top module: `io_port_unit`

## Requirements
- R1: The ports respond only when `bus_mem_io` is 0 (I/O cycle). In a cycle with `bus_mem_io` = 1 (memory cycle), reads never assert `rd_drive` and writes never change `led_out`.
- R2: With `WIDE_DECODE` = 1, address bits 15:0 must match the port address. With `WIDE_DECODE` = 0, only bits 7:0 are compared and bits 15:8 are ignored.
- R3: During an I/O read (`bus_rd` = 1) whose address matches `IN_PORT`, `rd_drive` is 1 and `rd_data` equals `sw_in` combinationally. At all other times `rd_drive` is 0 and `rd_data` is all zeros. This includes reads of `OUT_PORT` and write cycles.
- R4: An I/O write (`bus_wr` = 1) whose address matches `OUT_PORT` loads `bus_wdata` into `led_out` at the next rising clock edge. Bits 7:0 go into the low byte lane and bits 15:8 go into the high byte lane. A later write replaces the earlier value.
- R5: A write to any other address, and any read, leaves `led_out` unchanged.
- R6: Driving `rst_n` low clears `led_out` to zero at once, without waiting for a clock. The internal reset is released on the second rising edge after `rst_n` rises.
- R7: The port addresses default to `IN_PORT` = 16'h00F0 and `OUT_PORT` = 16'h00F2, and parameter overrides move both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Port address |
| bus_mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_wdata | input | 16 | Write data from the processor |
| sw_in | input | 16 | Switch levels |
| rd_data | output | 16 | Read data, zero when not driving |
| rd_drive | output | 1 | High while the input port drives the read data |
| led_out | output | 16 | Latched output port value |

## Verification
The case that is hardest to reach is an address that matches a port in its low byte but not in its high byte. Such an address must be accepted under 8-bit decoding and rejected under 16-bit decoding. To reach it, the bench runs a second instance with 8-bit decoding and moved port addresses on the same bus as the default instance. Each aliased access then has a known, and different, expected result in the two instances. Memory-cycle accesses to exact port addresses are also driven, and so is a reset asserted between clock edges, so that the asynchronous clear can be seen before any edge arrives.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int BUS_AW = 16;
  localparam int LANE_W = 8;

  typedef struct packed {
    logic rd_hit;
    logic wr_hit;
  } io_sel_t;
endpackage

// File: rtl/io_rst_sync.sv
module io_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_port_pkg::*;
#(
  parameter bit                WIDE_DECODE = 1'b1,
  parameter logic [BUS_AW-1:0] IN_PORT     = 16'h00F0,
  parameter logic [BUS_AW-1:0] OUT_PORT    = 16'h00F2
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic              mem_io,
  input  logic              rd,
  input  logic              wr,
  output io_sel_t           sel
);
  localparam int CMP_W = WIDE_DECODE ? BUS_AW : 8;

  logic io_cycle;
  logic in_match;
  logic out_match;

  always_comb begin
    io_cycle   = ~mem_io;
    in_match   = (addr[CMP_W-1:0] == IN_PORT[CMP_W-1:0]);
    out_match  = (addr[CMP_W-1:0] == OUT_PORT[CMP_W-1:0]);
    sel.rd_hit = io_cycle & rd & in_match;
    sel.wr_hit = io_cycle & wr & out_match;
  end
endmodule

// File: rtl/io_in_buffer.sv
module io_in_buffer #(
  parameter int DATA_W = 16
) (
  input  logic              enable,
  input  logic [DATA_W-1:0] sw,
  output logic [DATA_W-1:0] rdata,
  output logic              drive
);
  always_comb begin
    drive = enable;
    rdata = enable ? sw : '0;
  end
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch
  import io_port_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_d;
    logic [LANE_W-1:0] lane_q;

    always_comb begin
      lane_d = lane_q;
      if (load) lane_d = wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign q[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/io_port_unit.sv
module io_port_unit
  import io_port_pkg::*;
#(
  parameter bit                WIDE_DECODE = 1'b1,
  parameter logic [BUS_AW-1:0] IN_PORT     = 16'h00F0,
  parameter logic [BUS_AW-1:0] OUT_PORT    = 16'h00F2,
  parameter int                DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_mem_io,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] sw_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic [DATA_W-1:0] led_out
);
  logic    rst_s_n;
  io_sel_t sel;

  io_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  io_addr_decode #(
    .WIDE_DECODE (WIDE_DECODE),
    .IN_PORT     (IN_PORT),
    .OUT_PORT    (OUT_PORT)
  ) u_dec (
    .addr   (bus_addr),
    .mem_io (bus_mem_io),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .sel    (sel)
  );

  io_in_buffer #(.DATA_W(DATA_W)) u_in (
    .enable (sel.rd_hit),
    .sw     (sw_in),
    .rdata  (rd_data),
    .drive  (rd_drive)
  );

  io_out_latch #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (sel.wr_hit),
    .wdata (bus_wdata),
    .q     (led_out)
  );

  AST_MEM_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_mem_io |-> !rd_drive); // R1
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus_rd |-> (!rd_drive && rd_data == '0)); // R3
  AST_DRIVE_SHOWS_SW: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_drive |-> (rd_data == sw_in)); // R3
  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_s_n)
    sel.wr_hit |=> (led_out == $past(bus_wdata))); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !sel.wr_hit |=> $stable(led_out)); // R5
  AST_MEM_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_mem_io || !bus_wr) |=> $stable(led_out)); // R1
endmodule

// File: tb/tb_io_port_unit.sv
module tb_io_port_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_mem_io, bus_rd, bus_wr;
  logic [15:0] bus_wdata, sw_in;
  logic [15:0] rd_data, led_out, rd_data8, led_out8;
  logic        rd_drive, rd_drive8;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  io_port_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_mem_io(bus_mem_io),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .sw_in(sw_in),
    .rd_data(rd_data), .rd_drive(rd_drive), .led_out(led_out)
  );

  io_port_unit #(.WIDE_DECODE(1'b0), .IN_PORT(16'h0044), .OUT_PORT(16'h0046)) dut8 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_mem_io(bus_mem_io),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .sw_in(sw_in),
    .rd_data(rd_data8), .rd_drive(rd_drive8), .led_out(led_out8)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    bus_rd = 1'b0; bus_wr = 1'b0; bus_mem_io = 1'b0;
    bus_addr = 16'h0000; bus_wdata = 16'h0000;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic mio);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_mem_io = mio; bus_wr = 1'b1;
    @(negedge clk);
    bus_idle();
    #1;
  endtask

  task automatic start_read(input logic [15:0] a, input logic mio);
    @(negedge clk);
    bus_addr = a; bus_mem_io = mio; bus_rd = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    bus_idle(); sw_in = 16'h0000; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R6", "led after reset", led_out, 16'h0000);
    check("R6", "led8 after reset", led_out8, 16'h0000);
    check("R3", "idle drive", {15'b0, rd_drive}, 16'h0000);
    check("R3", "idle rdata", rd_data, 16'h0000);
  endtask

  task automatic t_read_input();
    sw_in = 16'hA5C3;
    start_read(16'h00F0, 1'b0);
    check("R3", "drive on port read", {15'b0, rd_drive}, 16'h0001);
    check("R3", "rdata on port read", rd_data, 16'hA5C3);
    check("R7", "moved in-port ignores F0", {15'b0, rd_drive8}, 16'h0000);
    sw_in = 16'h0F1E;
    #1;
    check("R3", "rdata follows switches", rd_data, 16'h0F1E);
    @(negedge clk); bus_idle(); #1;
    check("R3", "released after read", rd_data, 16'h0000);
  endtask

  task automatic t_write_output();
    do_write(16'h00F2, 16'h1234, 1'b0);
    check("R4", "led after write", led_out, 16'h1234);
    check("R4", "low lane", {8'h00, led_out[7:0]}, 16'h0034);
    check("R4", "high lane", {8'h00, led_out[15:8]}, 16'h0012);
    check("R7", "moved out-port ignores F2", led_out8, 16'h0000);
  endtask

  task automatic t_no_effect();
    do_write(16'h00F4, 16'hFFFF, 1'b0);
    check("R5", "write other addr", led_out, 16'h1234);
    do_write(16'h00F2, 16'hDEAD, 1'b1);
    check("R1", "memory write to out port", led_out, 16'h1234);
    start_read(16'h00F2, 1'b0);
    check("R3", "read of out port no drive", {15'b0, rd_drive}, 16'h0000);
    check("R3", "read of out port rdata", rd_data, 16'h0000);
    @(negedge clk); bus_idle(); #1;
    check("R5", "read leaves led", led_out, 16'h1234);
    start_read(16'h00F0, 1'b1);
    check("R1", "memory read no drive", {15'b0, rd_drive}, 16'h0000);
    check("R1", "memory read rdata", rd_data, 16'h0000);
    @(negedge clk); bus_idle();
    @(negedge clk); bus_addr = 16'h00F0; bus_wr = 1'b1; #1;
    check("R3", "write to in port no drive", {15'b0, rd_drive}, 16'h0000);
    @(negedge clk); bus_idle(); #1;
  endtask

  task automatic t_decode_width();
    do_write(16'h12F2, 16'hBEEF, 1'b0);
    check("R2", "wide ignores 12F2", led_out, 16'h1234);
    check("R2", "narrow: F2 is not 46", led_out8, 16'h0000);
    do_write(16'h1246, 16'h5A5A, 1'b0);
    check("R2", "narrow aliases 1246", led_out8, 16'h5A5A);
    check("R2", "wide ignores 1246", led_out, 16'h1234);
    sw_in = 16'h7E81;
    start_read(16'h3344, 1'b0);
    check("R2", "narrow read alias drive", {15'b0, rd_drive8}, 16'h0001);
    check("R7", "narrow read alias data", rd_data8, 16'h7E81);
    check("R2", "wide read 3344 no drive", {15'b0, rd_drive}, 16'h0000);
    @(negedge clk); bus_idle(); #1;
  endtask

  task automatic t_overwrite();
    do_write(16'h00F2, 16'h00FF, 1'b0);
    check("R4", "second write replaces", led_out, 16'h00FF);
    check("R2", "narrow unaffected", led_out8, 16'h5A5A);
  endtask

  task automatic t_reset_midrun();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R6", "async clear before edge", led_out, 16'h0000);
    check("R6", "async clear narrow", led_out8, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_write(16'h00F2, 16'hC001, 1'b0);
    check("R6", "write works after release", led_out, 16'hC001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_read_input();
    t_write_output();
    t_no_effect();
    t_decode_width();
    t_overwrite();
    t_reset_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule